// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the hardware side of taking an exception on a processor with a 16-bit data bus. The exception has already been chosen, and an 8-bit vector number comes with it. On a request, the block takes a snapshot of the status word and forces the processor into supervisor mode with tracing off. For an interrupt, it also loads the interrupt mask from the request level. It then writes a three-word context frame onto the supervisor stack. Last, it fetches the handler address from the vector table and delivers it as the new program counter.

The same sequencer also performs the return path. It reads the status word and program counter back from a frame at the given stack pointer. The block tracks whether the processor is in the normal, exception or halted execution state. Two things lead to the halted state. An external halt request is taken between sequences and held until it is released. A bus error during one of the sequencer's own cycles is a double fault and halts the processor until reset.

All memory traffic uses a simple request/ready word port. Each cycle is held until ready is seen, so any number of wait states can be inserted.

Top module: `exc_entry_seq`

## Requirements
- R1: On entry, the status output has bit 15 (trace) cleared and bit 13 (supervisor) set, and every other bit is kept from `sr_i`. For a non-interrupt entry, this includes the mask in bits 10:8. The adjusted value is visible before the first stack write.
- R2: For an interrupt entry (`exc_irq_i`=1), bits 10:8 of the status output are replaced by `irq_level_i`.
- R3: The vector address is `exc_vec_i` times 4. The handler address is read as two word cycles, the high word at that address and then the low word at address+2. `pc_o` becomes {high, low}, truncated to the address width.
- R4: The entry frame is written as three word cycles in this order: PC low word at SSP-2, then PC high word at SSP-4, then at SSP-6 the status word as it was before R1 was applied. `ssp_o` becomes SSP-6, and the stack writes come before the vector reads.
- R5: A memory cycle keeps its request, address, write flag and write data unchanged until `mem_rdy_i` is high at a clock edge. Wait states change only timing, never results.
- R6: `done_o` is a one-cycle pulse in the cycle when `sr_o`, `pc_o` and `ssp_o` hold their final values. A request that arrives while a sequence is running is dropped. If entry and return are requested in the same cycle, entry wins.
- R7: A return reads three word cycles: the status word at SSP, the PC high word at SSP+2 and the PC low word at SSP+4. It loads `sr_o` and `pc_o` from them and sets `ssp_o` to SSP+6.
- R8: `exec_state_o` is encoded as 2'b00 normal, 2'b01 exception and 2'b10 halted, and 2'b11 never appears. Entry moves the state to exception. After a return, the state is exception if the restored bit 13 is 1, and normal otherwise.
- R9: `halt_i` takes effect only once the sequencer is idle, so a running sequence completes first. While halted, no memory cycle is issued and requests are dropped. When `halt_i` falls, the state goes back to what it was before the halt.
- R10: A `mem_err_i` on any sequencer cycle aborts the sequence with no further cycles and no done pulse. The state becomes halted and stays halted regardless of `halt_i` until reset.
- R11: After reset the state is normal, `mem_req_o` and `done_o` are low, and `sr_o`, `pc_o` and `ssp_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Start exception entry |
| exc_vec_i | input | 8 | Vector number |
| exc_irq_i | input | 1 | The exception is an interrupt |
| irq_level_i | input | 3 | Interrupt level to load into the mask |
| rte_req_i | input | 1 | Start return from exception |
| halt_i | input | 1 | External halt request |
| sr_i | input | 16 | Current status word |
| pc_i | input | 24 | Program counter to save |
| ssp_i | input | 24 | Current supervisor stack pointer |
| mem_req_o | output | 1 | Memory cycle request |
| mem_we_o | output | 1 | Memory cycle is a write |
| mem_addr_o | output | 24 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_rdy_i | input | 1 | Memory cycle completes this edge |
| mem_err_i | input | 1 | Bus error on the completing cycle |
| sr_o | output | 16 | Status word |
| pc_o | output | 24 | Program counter |
| ssp_o | output | 24 | Supervisor stack pointer |
| done_o | output | 1 | Sequence finished, outputs valid |
| exec_state_o | output | 2 | Execution state |

## Verification
Entry is run with four input patterns:
- a trap-style vector with trace set and a non-zero mask, which shows that only T and S change;
- an interrupt at level 5 with a different incoming mask, which shows that the mask is replaced;
- vectors 255 and 0, which exercise the top and bottom of the vector table address range;
- zero, one and two wait states, each with distinct PC, stack and handler values, so that a swapped frame slot, a wrong push order or a wrong word order in the fetch shows up as a wrong memory value or a wrong cycle address.

The return path is tried with frames whose saved supervisor bit is 0 and 1, which separates the normal and exception outcomes. A bus error injected on the second stack push, together with halt raised while idle and while busy, separates the latched double-fault halt from the releasable one.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
package exc_seq_pkg;
  typedef enum logic [1:0] {
    XS_NORMAL = 2'b00,
    XS_EXCEPT = 2'b01,
    XS_HALTED = 2'b10
  } exec_state_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_ADJ,
    SQ_VEC,
    SQ_PUSH_PCL,
    SQ_PUSH_PCH,
    SQ_PUSH_SR,
    SQ_VEC_HI,
    SQ_VEC_LO,
    SQ_RD_SR,
    SQ_RD_PCH,
    SQ_RD_PCL,
    SQ_DONE
  } seq_state_e;

  localparam int SR_T_BIT    = 15;
  localparam int SR_S_BIT    = 13;
  localparam int SR_MASK_LSB = 8;
endpackage

// File: rtl/exc_sr_adjust.sv
`timescale 1ns/1ps
module exc_sr_adjust
  import exc_seq_pkg::*;
#(
  parameter int SR_W   = 16,
  parameter int MASK_W = 3
) (
  input  logic [SR_W-1:0]   sr_i,
  input  logic              is_irq_i,
  input  logic [MASK_W-1:0] level_i,
  output logic [SR_W-1:0]   sr_o
);
  always_comb begin
    sr_o = sr_i;
    sr_o[SR_T_BIT] = 1'b0;
    sr_o[SR_S_BIT] = 1'b1;
    if (is_irq_i) sr_o[SR_MASK_LSB +: MASK_W] = level_i;
  end
endmodule

// File: rtl/exc_frame_addr.sv
`timescale 1ns/1ps
module exc_frame_addr
  import exc_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  seq_state_e            state_i,
  input  logic [ADDR_W-1:0]     sp_i,
  input  logic [ADDR_W-1:0]     va_i,
  input  logic [2*DATA_W-1:0]   pc_ext_i,
  input  logic [DATA_W-1:0]     saved_sr_i,
  output logic                  req_o,
  output logic                  we_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [DATA_W-1:0]     wdata_o
);
  localparam logic [ADDR_W-1:0] WB = ADDR_W'(DATA_W / 8);

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      SQ_PUSH_PCL: begin we_o = 1'b1; addr_o = sp_i - WB;
                         wdata_o = pc_ext_i[DATA_W-1:0]; end
      SQ_PUSH_PCH: begin we_o = 1'b1; addr_o = sp_i - 2*WB;
                         wdata_o = pc_ext_i[2*DATA_W-1:DATA_W]; end
      SQ_PUSH_SR:  begin we_o = 1'b1; addr_o = sp_i - 3*WB;
                         wdata_o = saved_sr_i; end
      SQ_VEC_HI:   addr_o = va_i;
      SQ_VEC_LO:   addr_o = va_i + WB;
      SQ_RD_SR:    addr_o = sp_i;
      SQ_RD_PCH:   addr_o = sp_i + WB;
      SQ_RD_PCL:   addr_o = sp_i + 2*WB;
      default:     req_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_exec_track.sv
`timescale 1ns/1ps
module exc_exec_track
  import exc_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        entry_i,
  input  logic        ret_i,
  input  logic        ret_super_i,
  input  logic        fault_i,
  input  logic        idle_i,
  input  logic        halt_i,
  output exec_state_e state_o
);
  exec_state_e st_q, resume_q;
  logic        fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= XS_NORMAL;
      resume_q <= XS_NORMAL;
      fault_q  <= 1'b0;
    end else if (fault_i) begin
      st_q    <= XS_HALTED;
      fault_q <= 1'b1;
    end else if (!fault_q) begin
      if (st_q == XS_HALTED) begin
        if (!halt_i) st_q <= resume_q;
      end else if (entry_i) begin
        st_q <= XS_EXCEPT;
      end else if (ret_i) begin
        st_q <= ret_super_i ? XS_EXCEPT : XS_NORMAL;
      end else if (halt_i && idle_i) begin
        resume_q <= st_q;
        st_q     <= XS_HALTED;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8,
  parameter int MASK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic [VEC_W-1:0]  exc_vec_i,
  input  logic              exc_irq_i,
  input  logic [MASK_W-1:0] irq_level_i,
  input  logic              rte_req_i,
  input  logic              halt_i,
  input  logic [DATA_W-1:0] sr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ssp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i,
  input  logic              mem_err_i,
  output logic [DATA_W-1:0] sr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ssp_o,
  output logic              done_o,
  output logic [1:0]        exec_state_o
);
  localparam int PC_EXT_W    = 2 * DATA_W;
  localparam int FRAME_WORDS = 1 + PC_EXT_W / DATA_W;
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(FRAME_WORDS * DATA_W / 8);

  seq_state_e        seq_q;
  exec_state_e       xs;
  logic [VEC_W-1:0]  vec_q;
  logic              irq_q, ret_q;
  logic [MASK_W-1:0] lvl_q;
  logic [DATA_W-1:0] sr_q, saved_sr_q, pch_q, sr_adj;
  logic [ADDR_W-1:0] pc_q, ssp_q, base_sp_q, va_q;
  logic [PC_EXT_W-1:0] pc_ext;
  logic              accept, cyc_ok, cyc_err;

  assign accept  = (seq_q == SQ_IDLE) && !halt_i && (xs != XS_HALTED);
  assign cyc_ok  = mem_req_o && mem_rdy_i && !mem_err_i;
  assign cyc_err = mem_req_o && mem_rdy_i && mem_err_i;
  assign pc_ext  = PC_EXT_W'(pc_q);

  exc_sr_adjust #(.SR_W(DATA_W), .MASK_W(MASK_W)) u_adj (
    .sr_i(saved_sr_q), .is_irq_i(irq_q), .level_i(lvl_q), .sr_o(sr_adj)
  );

  exc_frame_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .state_i(seq_q), .sp_i(base_sp_q), .va_i(va_q), .pc_ext_i(pc_ext),
    .saved_sr_i(saved_sr_q), .req_o(mem_req_o), .we_o(mem_we_o),
    .addr_o(mem_addr_o), .wdata_o(mem_wdata_o)
  );

  exc_exec_track u_track (
    .clk_i, .rst_ni,
    .entry_i(accept && exc_req_i),
    .ret_i((seq_q == SQ_DONE) && ret_q),
    .ret_super_i(sr_q[SR_S_BIT]),
    .fault_i(cyc_err),
    .idle_i(seq_q == SQ_IDLE),
    .halt_i,
    .state_o(xs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= SQ_IDLE;
      vec_q      <= '0;
      irq_q      <= 1'b0;
      ret_q      <= 1'b0;
      lvl_q      <= '0;
      sr_q       <= '0;
      saved_sr_q <= '0;
      pch_q      <= '0;
      pc_q       <= '0;
      ssp_q      <= '0;
      base_sp_q  <= '0;
      va_q       <= '0;
    end else begin
      unique case (seq_q)
        SQ_IDLE: begin
          if (accept && exc_req_i) begin
            saved_sr_q <= sr_i;
            pc_q       <= pc_i;
            base_sp_q  <= ssp_i;
            vec_q      <= exc_vec_i;
            irq_q      <= exc_irq_i;
            lvl_q      <= irq_level_i;
            ret_q      <= 1'b0;
            seq_q      <= SQ_ADJ;
          end else if (accept && rte_req_i) begin
            base_sp_q <= ssp_i;
            ret_q     <= 1'b1;
            seq_q     <= SQ_RD_SR;
          end
        end
        SQ_ADJ: begin
          sr_q  <= sr_adj;
          seq_q <= SQ_VEC;
        end
        SQ_VEC: begin
          va_q  <= ADDR_W'({vec_q, 2'b00});
          ssp_q <= base_sp_q - FRAME_BYTES;
          seq_q <= SQ_PUSH_PCL;
        end
        SQ_DONE: seq_q <= SQ_IDLE;
        default: begin
          if (cyc_err) begin
            seq_q <= SQ_IDLE;
          end else if (cyc_ok) begin
            unique case (seq_q)
              SQ_PUSH_PCL: seq_q <= SQ_PUSH_PCH;
              SQ_PUSH_PCH: seq_q <= SQ_PUSH_SR;
              SQ_PUSH_SR:  seq_q <= SQ_VEC_HI;
              SQ_VEC_HI: begin
                pch_q <= mem_rdata_i;
                seq_q <= SQ_VEC_LO;
              end
              SQ_VEC_LO: begin
                pc_q  <= ADDR_W'({pch_q, mem_rdata_i});
                seq_q <= SQ_DONE;
              end
              SQ_RD_SR: begin
                sr_q  <= mem_rdata_i;
                seq_q <= SQ_RD_PCH;
              end
              SQ_RD_PCH: begin
                pch_q <= mem_rdata_i;
                seq_q <= SQ_RD_PCL;
              end
              SQ_RD_PCL: begin
                pc_q  <= ADDR_W'({pch_q, mem_rdata_i});
                ssp_q <= base_sp_q + FRAME_BYTES;
                seq_q <= SQ_DONE;
              end
              default: seq_q <= SQ_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign sr_o         = sr_q;
  assign pc_o         = pc_q;
  assign ssp_o        = ssp_q;
  assign done_o       = (seq_q == SQ_DONE);
  assign exec_state_o = xs;
endmodule

// File: rtl/exc_entry_seq_chk.sv
`timescale 1ns/1ps
module exc_entry_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_rdy_i,
  input logic              mem_err_i,
  input logic [DATA_W-1:0] sr_o,
  input logic              done_o,
  input logic [1:0]        exec_state_o
);
  assert_sr_forced_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> sr_o[13] && !sr_o[15]);

  assert_cycle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_state_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_state_o != 2'b11);

  assert_halt_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_state_o == 2'b10 |-> !mem_req_o);

  assert_fault_halts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rdy_i && mem_err_i |=> exec_state_o == 2'b10 && !mem_req_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdy_i(mem_rdy_i),
  .mem_err_i(mem_err_i), .sr_o(sr_o), .done_o(done_o), .exec_state_o(exec_state_o)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exc_req = 1'b0, exc_irq = 1'b0, rte_req = 1'b0, halt = 1'b0;
  logic [7:0]  exc_vec = '0;
  logic [2:0]  irq_lvl = '0;
  logic [15:0] sr_in = '0;
  logic [23:0] pc_in = '0, ssp_in = '0;
  logic        mem_req, mem_we, mem_rdy, mem_err;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] sr_out;
  logic [23:0] pc_out, ssp_out;
  logic        done;
  logic [1:0]  xstate;

  logic [15:0] mem [0:4095];
  logic [23:0] log_addr [0:255];
  logic        log_we [0:255];
  int          log_n = 0, done_cnt = 0, wcnt = 0, wait_n = 0;
  logic        err_arm = 1'b0;
  logic [23:0] err_addr = '0;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_ni), .exc_req_i(exc_req), .exc_vec_i(exc_vec),
    .exc_irq_i(exc_irq), .irq_level_i(irq_lvl), .rte_req_i(rte_req), .halt_i(halt),
    .sr_i(sr_in), .pc_i(pc_in), .ssp_i(ssp_in), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rdy_i(mem_rdy), .mem_err_i(mem_err), .sr_o(sr_out), .pc_o(pc_out),
    .ssp_o(ssp_out), .done_o(done), .exec_state_o(xstate)
  );

  assign mem_rdy   = mem_req && (wcnt >= wait_n);
  assign mem_err   = mem_rdy && err_arm && (mem_addr == err_addr);
  assign mem_rdata = mem[mem_addr[12:1]];

  always @(posedge clk) begin
    if (mem_req && !mem_rdy) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req && mem_rdy) begin
      log_addr[log_n[7:0]] <= mem_addr;
      log_we[log_n[7:0]]   <= mem_we;
      log_n <= log_n + 1;
      if (mem_we && !mem_err) mem[mem_addr[12:1]] <= mem_wdata;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk_eq(input string what, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, what, act, exp);
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  function automatic logic [15:0] exp_sr(input logic [15:0] s, input bit irq, input logic [2:0] l);
    logic [15:0] r;
    r = (s & 16'h7FFF) | 16'h2000;
    if (irq) r = (r & 16'hF8FF) | {5'b0, l, 8'h00};
    return r;
  endfunction

  task automatic t_reset();
    chk_eq("R11 state after reset", {30'b0, xstate}, 32'h0);
    chk_eq("R11 no request after reset", {31'b0, mem_req}, 32'h0);
    chk_eq("R11 done low after reset", {31'b0, done}, 32'h0);
    chk_eq("R11 pc zero after reset", {8'b0, pc_out}, 32'h0);
  endtask

  task automatic t_entry(input logic [7:0] vec, input logic [15:0] sr, input logic [23:0] pc,
                         input logic [23:0] ssp, input bit irq, input logic [2:0] lvl,
                         input int waits, input bit poke_busy);
    int base, dbase;
    bit seen;
    logic [23:0] va, hpc;
    va  = {14'b0, vec, 2'b00};
    hpc = {8'h40, vec, 8'h00};
    mem[va[12:1]]     = 16'h0040;
    mem[va[12:1] + 1] = {vec, 8'h00};
    wait_n = waits;
    base = log_n; dbase = done_cnt;
    @(negedge clk);
    exc_vec = vec; sr_in = sr; pc_in = pc; ssp_in = ssp; exc_irq = irq; irq_lvl = lvl;
    exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    if (poke_busy) begin
      repeat (2) @(negedge clk);
      exc_vec = 8'd9; exc_irq = 1'b0; exc_req = 1'b1;
      @(negedge clk);
      exc_req = 1'b0;
    end
    wait_done(seen);
    chk_eq("R6 entry done seen", {31'b0, seen}, 32'h1);
    chk_eq(irq ? "R2 interrupt status" : "R1 status adjust", {16'b0, sr_out}, {16'b0, exp_sr(sr, irq, lvl)});
    chk_eq("R3 handler pc", {8'b0, pc_out}, {8'b0, hpc});
    chk_eq("R4 ssp minus frame", {8'b0, ssp_out}, {8'b0, ssp - 24'd6});
    chk_eq("R8 state exception", {30'b0, xstate}, 32'h1);
    chk_eq("R4 cycle count", log_n - base, 5);
    chk_eq("R4 push1 addr pc low", {8'b0, log_addr[base]}, {8'b0, ssp - 24'd2});
    chk_eq("R4 push2 addr pc high", {8'b0, log_addr[base+1]}, {8'b0, ssp - 24'd4});
    chk_eq("R4 push3 addr sr", {8'b0, log_addr[base+2]}, {8'b0, ssp - 24'd6});
    chk_eq("R4 pushes are writes", {29'b0, log_we[base], log_we[base+1], log_we[base+2]}, 32'h7);
    chk_eq("R3 fetch hi addr", {8'b0, log_addr[base+3]}, {8'b0, va});
    chk_eq("R3 fetch lo addr", {8'b0, log_addr[base+4]}, {8'b0, va + 24'd2});
    chk_eq("R4 frame saved sr", {16'b0, mem[(ssp - 24'd6) >> 1]}, {16'b0, sr});
    chk_eq("R4 frame pc hi", {16'b0, mem[(ssp - 24'd4) >> 1]}, {24'b0, pc[23:16]});
    chk_eq("R4 frame pc lo", {16'b0, mem[(ssp - 24'd2) >> 1]}, {16'b0, pc[15:0]});
    @(negedge clk);
    chk_eq("R6 done one cycle", {31'b0, done}, 32'h0);
    if (poke_busy) begin
      repeat (10) @(negedge clk);
      chk_eq("R6 busy request dropped cycles", log_n - base, 5);
      chk_eq("R6 busy request dropped done", done_cnt - dbase, 1);
    end
  endtask

  task automatic t_rte(input logic [23:0] ssp, input logic [15:0] esr, input logic [23:0] epc,
                       input logic [1:0] estate);
    int base;
    bit seen;
    base = log_n;
    wait_n = 1;
    @(negedge clk);
    ssp_in = ssp; rte_req = 1'b1;
    @(negedge clk);
    rte_req = 1'b0;
    wait_done(seen);
    chk_eq("R7 return done seen", {31'b0, seen}, 32'h1);
    chk_eq("R7 restored sr", {16'b0, sr_out}, {16'b0, esr});
    chk_eq("R7 restored pc", {8'b0, pc_out}, {8'b0, epc});
    chk_eq("R7 ssp plus frame", {8'b0, ssp_out}, {8'b0, ssp + 24'd6});
    chk_eq("R7 read count", log_n - base, 3);
    chk_eq("R7 read sr addr", {8'b0, log_addr[base]}, {8'b0, ssp});
    chk_eq("R7 read pch addr", {8'b0, log_addr[base+1]}, {8'b0, ssp + 24'd2});
    chk_eq("R7 read pcl addr", {8'b0, log_addr[base+2]}, {8'b0, ssp + 24'd4});
    @(negedge clk);
    chk_eq("R8 state after return", {30'b0, xstate}, {30'b0, estate});
  endtask

  task automatic t_halt_idle();
    int base;
    base = log_n;
    @(negedge clk); halt = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R9 halted while idle", {30'b0, xstate}, 32'h2);
    exc_vec = 8'd4; exc_req = 1'b1;
    @(negedge clk); exc_req = 1'b0;
    repeat (5) @(negedge clk);
    chk_eq("R9 no cycles while halted", log_n - base, 0);
    chk_eq("R9 still halted", {30'b0, xstate}, 32'h2);
    halt = 1'b0;
    repeat (2) @(negedge clk);
    chk_eq("R9 resume prior state", {30'b0, xstate}, 32'h1);
    chk_eq("R9 request while halted not kept", log_n - base, 0);
  endtask

  task automatic t_halt_busy();
    int base;
    bit seen;
    base = log_n;
    wait_n = 2;
    mem[7*2] = 16'h0040; mem[7*2+1] = 16'h0700;
    @(negedge clk);
    exc_vec = 8'd7; exc_irq = 1'b0; sr_in = 16'h0000; pc_in = 24'h000200; ssp_in = 24'h001A00;
    exc_req = 1'b1;
    @(negedge clk); exc_req = 1'b0;
    @(negedge clk); halt = 1'b1;
    wait_done(seen);
    chk_eq("R9 sequence completes under halt", {31'b0, seen}, 32'h1);
    chk_eq("R9 all cycles done under halt", log_n - base, 5);
    repeat (3) @(negedge clk);
    chk_eq("R9 halted after sequence", {30'b0, xstate}, 32'h2);
    halt = 1'b0;
    repeat (2) @(negedge clk);
    chk_eq("R9 resumes exception", {30'b0, xstate}, 32'h1);
  endtask

  task automatic t_fault();
    int base, dbase;
    base = log_n; dbase = done_cnt;
    wait_n = 0;
    err_arm = 1'b1; err_addr = 24'h001BFC;
    @(negedge clk);
    exc_vec = 8'd3; sr_in = 16'h0000; pc_in = 24'h000300; ssp_in = 24'h001C00;
    exc_req = 1'b1;
    @(negedge clk); exc_req = 1'b0;
    repeat (20) @(negedge clk);
    chk_eq("R10 halted on double fault", {30'b0, xstate}, 32'h2);
    chk_eq("R10 aborted after error cycle", log_n - base, 2);
    chk_eq("R10 no done on fault", done_cnt - dbase, 0);
    err_arm = 1'b0;
    exc_vec = 8'd5; exc_req = 1'b1;
    @(negedge clk); exc_req = 1'b0;
    repeat (10) @(negedge clk);
    chk_eq("R10 stays halted without halt input", {30'b0, xstate}, 32'h2);
    chk_eq("R10 no cycles after fault", log_n - base, 2);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_eq("R11 reset clears fault halt", {30'b0, xstate}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry(8'd5, 16'h8016, 24'h001040, 24'h001000, 1'b0, 3'd0, 0, 1'b0);
    t_rte(24'h000FFA, 16'h8016, 24'h001040, 2'b00);
    t_entry(8'd27, 16'h0300, 24'h00ABCD, 24'h000800, 1'b1, 3'd5, 2, 1'b1);
    t_entry(8'd255, 16'h0715, 24'h0F1234, 24'h001400, 1'b0, 3'd0, 1, 1'b0);
    t_entry(8'd0, 16'hA21F, 24'h005678, 24'h001600, 1'b0, 3'd0, 0, 1'b0);
    mem[12'hC00] = 16'h2704; mem[12'hC01] = 16'h0012; mem[12'hC02] = 16'h3456;
    t_rte(24'h001800, 16'h2704, 24'h123456, 2'b01);
    t_halt_idle();
    t_halt_busy();
    t_fault();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule